// File: doc/BRIEF.md
# Execution-Aware Memory Protection Unit with Configuration Lock

This unit decides whether a memory access may proceed from two addresses: the address of the instruction that issues the access and the address it targets. There is no privilege level involved. Each of a fixed number of rules ties one code range to one data range and a set of permissions. A request is allowed when at least one enabled rule covers both addresses and grants the requested kind. If no rule does, a fault is raised in the same cycle, and the target address is captured for later inspection.

A trusted loader fills the rules and a small table of isolated-task descriptors through a write port. Each descriptor holds a code start, a code end and a saved stack pointer. Address values that fall outside a permitted loading window are refused. When loading is done, the loader issues a lock. From then on the rules and the table are frozen until reset, and every further write attempt is flagged. The table can be read back at any time through a read window.

Top module: `empu_top`

## Requirements
- R1: After reset no rule is enabled, so every valid access faults; `locked`, `cfg_err` and `fault_addr` read 0, and every table field reads 0.
- R2: An access is allowed when an enabled rule has `code_lo <= acc_pc <= code_hi` and `data_lo <= acc_addr <= data_hi` (all bounds inclusive) and grants the access kind. The kind encoding is 0 read, 1 write, 2 execute, 3 reserved. The rule permission field is bit0 read, bit1 write, bit2 execute, bit3 enable.
- R3: An access whose target is inside a rule's data range but whose instruction address lies outside that rule's code range gets no permission from that rule.
- R4: A matching rule that lacks the permission bit for the requested kind does not allow the access. Kind 3 is never allowed.
- R5: When several rules cover an access, it is allowed if any one of them grants the kind.
- R6: `fault` is combinational and rises in the cycle of the offending access. On the next clock edge `fault_addr` takes that access's target. Cycles without a fault leave `fault_addr` unchanged.
- R7: Before lock, a write of an address-valued field (rule fields 0 to 3, all table fields) whose value lies outside [LOAD_LO, LOAD_HI] is discarded and sets the sticky `cfg_err`. Write address layout: bit7 selects table (1) or rules (0), bits6:3 the entry, bits2:0 the field. Rule fields are 0 code_lo, 1 code_hi, 2 data_lo, 3 data_hi, 4 permissions. Table fields are 0 code start, 1 code end, 2 stack pointer.
- R8: A pulse on `cfg_lock` sets `locked` on the next edge. After that every write is discarded and sets `cfg_err`, and only reset clears `locked`.
- R9: Table entries written before lock read back through `tbl_ridx`/`tbl_rfield` (field 3 reads 0) combinationally, both before and after lock.
- R10: With `acc_valid` low, `fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration write address (space, entry, field) |
| cfg_wdata | input | AW | Configuration write value |
| cfg_lock | input | 1 | Freezes all configuration until reset |
| acc_valid | input | 1 | Access request present |
| acc_pc | input | AW | Instruction address of the requester |
| acc_addr | input | AW | Target address |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| fault | output | 1 | Access denied, same cycle |
| fault_addr | output | AW | Target of the latest denied access |
| locked | output | 1 | Configuration frozen |
| cfg_err | output | 1 | Sticky refused-write flag |
| tbl_ridx | input | 4 | Table read entry |
| tbl_rfield | input | 2 | Table read field |
| tbl_rdata | output | AW | Table read value |

## Verification
The bench probes the inclusive range edges on both the code side and the data side. A design with an off-by-one compare would fault at an exact boundary, or allow one address past it. Instruction addresses just outside the code range aim at a unit that ignores the requester: such a unit would let those accesses through. Overlapping rules with different permissions catch a unit that takes only the first match and so wrongly denies. A refused write followed by an access that depends on the old bound exposes a unit that stores the value anyway. Writes after lock, followed by read-back and accesses, expose a lock that does not hold or a flag that stays clear.

// File: rtl/empu_pkg.sv
package empu_pkg;
  localparam int CFG_AW   = 8;
  localparam int IDX_BITS = 4;
  localparam int FLD_BITS = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  // rule field selectors
  localparam logic [FLD_BITS-1:0] RF_CODE_LO = 3'd0;
  localparam logic [FLD_BITS-1:0] RF_CODE_HI = 3'd1;
  localparam logic [FLD_BITS-1:0] RF_DATA_LO = 3'd2;
  localparam logic [FLD_BITS-1:0] RF_DATA_HI = 3'd3;
  localparam logic [FLD_BITS-1:0] RF_PERM    = 3'd4;
  // table field selectors
  localparam logic [FLD_BITS-1:0] TF_CODE_LO = 3'd0;
  localparam logic [FLD_BITS-1:0] TF_CODE_HI = 3'd1;
  localparam logic [FLD_BITS-1:0] TF_STACK   = 3'd2;

  // permission bits
  localparam int PB_R  = 0;
  localparam int PB_W  = 1;
  localparam int PB_X  = 2;
  localparam int PB_EN = 3;

  // inclusive range test on zero-extended values
  function automatic logic in_span(logic [31:0] v, logic [31:0] lo, logic [31:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // does an enabled permission nibble grant this kind
  function automatic logic perm_grants(logic [3:0] perm, logic [1:0] kind);
    logic g;
    case (kind)
      ACC_READ:  g = perm[PB_R];
      ACC_WRITE: g = perm[PB_W];
      ACC_EXEC:  g = perm[PB_X];
      default:   g = 1'b0;
    endcase
    return perm[PB_EN] && g;
  endfunction
endpackage

// File: rtl/empu_rules.sv
module empu_rules
  import empu_pkg::*;
#(
  parameter int NRULES = 4,
  parameter int AW     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_BITS-1:0]        wr_idx,
  input  logic [FLD_BITS-1:0]        wr_field,
  input  logic [AW-1:0]              wr_data,
  output logic [NRULES-1:0][AW-1:0]  code_lo,
  output logic [NRULES-1:0][AW-1:0]  code_hi,
  output logic [NRULES-1:0][AW-1:0]  data_lo,
  output logic [NRULES-1:0][AW-1:0]  data_hi,
  output logic [NRULES-1:0][3:0]     perm
);
  for (genvar i = 0; i < NRULES; i++) begin : g_rule
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_BITS'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_lo[i] <= '0;
        code_hi[i] <= '0;
        data_lo[i] <= '0;
        data_hi[i] <= '0;
        perm[i]    <= '0;
      end else if (sel) begin
        case (wr_field)
          RF_CODE_LO: code_lo[i] <= wr_data;
          RF_CODE_HI: code_hi[i] <= wr_data;
          RF_DATA_LO: data_lo[i] <= wr_data;
          RF_DATA_HI: data_hi[i] <= wr_data;
          RF_PERM:    perm[i]    <= wr_data[3:0];
          default: ;
        endcase
      end
    end
  end

  // R8: rule storage only moves on an accepted write
  p_rules_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(code_lo) && $stable(code_hi) && $stable(data_lo)
               && $stable(data_hi) && $stable(perm));
endmodule

// File: rtl/empu_rule_check.sv
module empu_rule_check
  import empu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] code_lo,
  input  logic [AW-1:0] code_hi,
  input  logic [AW-1:0] data_lo,
  input  logic [AW-1:0] data_hi,
  input  logic [3:0]    perm,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    kind,
  output logic          covers,
  output logic          hit
);
  logic pc_in, addr_in;
  assign pc_in   = in_span(32'(pc),   32'(code_lo), 32'(code_hi));
  assign addr_in = in_span(32'(addr), 32'(data_lo), 32'(data_hi));
  assign covers  = pc_in && addr_in && perm[PB_EN];
  assign hit     = covers && perm_grants(perm, kind);

  // R4: reserved kind never grants
  always_comb begin
    if (kind == ACC_RSVD) a_rsvd_denied_r4: assert (!hit);
  end
endmodule

// File: rtl/empu_slots.sv
module empu_slots
  import empu_pkg::*;
#(
  parameter int NSLOTS = 4,
  parameter int AW     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_BITS-1:0]  wr_idx,
  input  logic [FLD_BITS-1:0]  wr_field,
  input  logic [AW-1:0]        wr_data,
  input  logic [IDX_BITS-1:0]  rd_idx,
  input  logic [1:0]           rd_field,
  output logic [AW-1:0]        rd_data
);
  logic [NSLOTS-1:0][AW-1:0] s_lo, s_hi, s_sp;

  for (genvar i = 0; i < NSLOTS; i++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_BITS'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_lo[i] <= '0;
        s_hi[i] <= '0;
        s_sp[i] <= '0;
      end else if (sel) begin
        case (wr_field)
          TF_CODE_LO: s_lo[i] <= wr_data;
          TF_CODE_HI: s_hi[i] <= wr_data;
          TF_STACK:   s_sp[i] <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSLOTS; i++) begin
      if (rd_idx == IDX_BITS'(i)) begin
        case (rd_field)
          2'd0:    rd_data = s_lo[i];
          2'd1:    rd_data = s_hi[i];
          2'd2:    rd_data = s_sp[i];
          default: rd_data = '0;
        endcase
      end
    end
  end

  // R8: table only moves on an accepted write
  p_slots_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(s_lo) && $stable(s_hi) && $stable(s_sp));
endmodule

// File: rtl/empu_top.sv
module empu_top
  import empu_pkg::*;
#(
  parameter int          NRULES  = 4,
  parameter int          NSLOTS  = 4,
  parameter int          AW      = 16,
  parameter logic [AW-1:0] LOAD_LO = 16'h0100,
  parameter logic [AW-1:0] LOAD_HI = 16'hEFFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [AW-1:0]       cfg_wdata,
  input  logic                cfg_lock,
  input  logic                acc_valid,
  input  logic [AW-1:0]       acc_pc,
  input  logic [AW-1:0]       acc_addr,
  input  logic [1:0]          acc_kind,
  output logic                fault,
  output logic [AW-1:0]       fault_addr,
  output logic                locked,
  output logic                cfg_err,
  input  logic [IDX_BITS-1:0] tbl_ridx,
  input  logic [1:0]          tbl_rfield,
  output logic [AW-1:0]       tbl_rdata
);
  // ---------------- configuration decode ----------------
  logic                 sp_table;
  logic [IDX_BITS-1:0]  c_idx;
  logic [FLD_BITS-1:0]  c_fld;
  logic                 rule_tgt, slot_tgt, addr_fld, win_ok;
  logic                 rule_wr, slot_wr, err_set;

  assign sp_table = cfg_addr[CFG_AW-1];
  assign c_idx    = cfg_addr[FLD_BITS +: IDX_BITS];
  assign c_fld    = cfg_addr[FLD_BITS-1:0];

  assign rule_tgt = !sp_table && (int'(c_idx) < NRULES) && (c_fld <= RF_PERM);
  assign slot_tgt =  sp_table && (int'(c_idx) < NSLOTS) && (c_fld <= TF_STACK);
  assign addr_fld = slot_tgt || (rule_tgt && (c_fld != RF_PERM));
  assign win_ok   = in_span(32'(cfg_wdata), 32'(LOAD_LO), 32'(LOAD_HI));

  assign rule_wr  = cfg_we && !locked && rule_tgt && (!addr_fld || win_ok);
  assign slot_wr  = cfg_we && !locked && slot_tgt && (!addr_fld || win_ok);
  assign err_set  = cfg_we && (locked || (addr_fld && !win_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked  <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      if (cfg_lock) locked  <= 1'b1;
      if (err_set)  cfg_err <= 1'b1;
    end
  end

  // ---------------- storage ----------------
  logic [NRULES-1:0][AW-1:0] r_clo, r_chi, r_dlo, r_dhi;
  logic [NRULES-1:0][3:0]    r_perm;

  empu_rules #(.NRULES(NRULES), .AW(AW)) u_rules (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rule_wr), .wr_idx(c_idx), .wr_field(c_fld), .wr_data(cfg_wdata),
    .code_lo(r_clo), .code_hi(r_chi), .data_lo(r_dlo), .data_hi(r_dhi),
    .perm(r_perm)
  );

  empu_slots #(.NSLOTS(NSLOTS), .AW(AW)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .wr_en(slot_wr), .wr_idx(c_idx), .wr_field(c_fld), .wr_data(cfg_wdata),
    .rd_idx(tbl_ridx), .rd_field(tbl_rfield), .rd_data(tbl_rdata)
  );

  // ---------------- access check ----------------
  logic [NRULES-1:0] hit_vec, cover_vec;

  for (genvar i = 0; i < NRULES; i++) begin : g_chk
    empu_rule_check #(.AW(AW)) u_chk (
      .code_lo(r_clo[i]), .code_hi(r_chi[i]),
      .data_lo(r_dlo[i]), .data_hi(r_dhi[i]),
      .perm(r_perm[i]),
      .pc(acc_pc), .addr(acc_addr), .kind(acc_kind),
      .covers(cover_vec[i]), .hit(hit_vec[i])
    );
  end

  logic any_hit;
  assign any_hit = |hit_vec;
  assign fault   = acc_valid && !any_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fault_addr <= '0;
    else if (fault) fault_addr <= acc_addr;
  end

  // ---------------- assertions ----------------
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !fault);

  p_fault_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault_addr == $past(acc_addr));

  p_fault_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |=> $stable(fault_addr));

  p_uncovered_denied_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cover_vec == '0) |-> fault);

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  p_locked_write_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && cfg_we) |=> cfg_err);

  p_no_write_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !rule_wr && !slot_wr);

  p_window_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && addr_fld && !win_ok) |=> cfg_err);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

// File: tb/tb_empu_top.sv
module tb_empu_top;
  import empu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        cfg_lock = 1'b0;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_pc = '0, acc_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic        fault;
  logic [15:0] fault_addr;
  logic        locked, cfg_err;
  logic [3:0]  tbl_ridx = '0;
  logic [1:0]  tbl_rfield = '0;
  logic [15:0] tbl_rdata;

  always #5 clk = ~clk;

  empu_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_lock(cfg_lock), .acc_valid(acc_valid),
    .acc_pc(acc_pc), .acc_addr(acc_addr), .acc_kind(acc_kind),
    .fault(fault), .fault_addr(fault_addr), .locked(locked),
    .cfg_err(cfg_err), .tbl_ridx(tbl_ridx), .tbl_rfield(tbl_rfield),
    .tbl_rdata(tbl_rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { bit exp_fault; string req; } item_t;
  item_t sb[$];
  event mon_ev;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard each time an access is ready to sample
  initial begin
    forever begin
      @(mon_ev);
      if (sb.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard actual=empty expected=item");
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(it.req, 32'(fault), 32'(it.exp_fault));
      end
    end
  end

  // rule address: space 0, entry, field
  function automatic logic [7:0] ra(int idx, logic [2:0] f);
    return {1'b0, 4'(idx), f};
  endfunction
  function automatic logic [7:0] ta(int idx, logic [2:0] f);
    return {1'b1, 4'(idx), f};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rule(input int i, input logic [15:0] clo, chi, dlo, dhi, input logic [3:0] p);
    wr(ra(i, RF_CODE_LO), clo);
    wr(ra(i, RF_CODE_HI), chi);
    wr(ra(i, RF_DATA_LO), dlo);
    wr(ra(i, RF_DATA_HI), dhi);
    wr(ra(i, RF_PERM), {12'b0, p});
  endtask

  // driver: drive access, push expectation, trigger sample before the edge
  task automatic acc(input logic [15:0] pc, ad, input logic [1:0] k, input bit ef, input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_pc = pc; acc_addr = ad; acc_kind = k;
    sb.push_back('{ef, req});
    #2 -> mon_ev;
    @(posedge clk);
    #1 acc_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input string req, input int i, input logic [1:0] f, input logic [15:0] exp);
    @(negedge clk);
    tbl_ridx = 4'(i); tbl_rfield = f;
    #1 chk(req, 32'(tbl_rdata), 32'(exp));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 locked", 32'(locked), 0);
    chk("R1 cfg_err", 32'(cfg_err), 0);
    chk("R1 fault_addr", 32'(fault_addr), 0);
    rd("R1 table", 0, 2'd2, 16'h0);
    acc(16'h0200, 16'h0300, ACC_READ, 1, "R1 no rule");
    // R10 idle
    @(negedge clk);
    acc_pc = 16'h0001; acc_addr = 16'h0002; acc_kind = ACC_RSVD;
    #1 chk("R10 idle", 32'(fault), 0);

    rule(0, 16'h1000, 16'h10FF, 16'h2000, 16'h20FF, 4'b1001);
    rule(1, 16'h1000, 16'h10FF, 16'h2080, 16'h217F, 4'b1010);
    rule(2, 16'h3000, 16'h30FF, 16'h1000, 16'h10FF, 4'b1100);

    acc(16'h1000, 16'h2000, ACC_READ,  0, "R2 low bounds");
    acc(16'h10FF, 16'h20FF, ACC_READ,  0, "R2 high bounds");
    acc(16'h1100, 16'h2000, ACC_READ,  1, "R3 pc above code");
    chk("R6 capture", 32'(fault_addr), 32'h2000);
    acc(16'h0FFF, 16'h2010, ACC_READ,  1, "R3 pc below code");
    acc(16'h1000, 16'h2000, ACC_WRITE, 1, "R4 no write bit");
    acc(16'h1000, 16'h2090, ACC_WRITE, 0, "R5 overlap write");
    acc(16'h1000, 16'h2090, ACC_READ,  0, "R5 overlap read");
    acc(16'h1000, 16'h2100, ACC_READ,  1, "R5 only write rule");
    chk("R6 capture2", 32'(fault_addr), 32'h2100);
    acc(16'h3000, 16'h1000, ACC_EXEC,  0, "R2 exec");
    chk("R6 hold", 32'(fault_addr), 32'h2100);
    acc(16'h3000, 16'h1000, ACC_READ,  1, "R4 exec-only read");
    acc(16'h1000, 16'h2000, ACC_RSVD,  1, "R4 reserved kind");
    acc(16'h1000, 16'h2100, ACC_READ,  1, "R6 same cycle");

    // R7 window rejection
    rule(3, 16'h4000, 16'h5000, 16'h6000, 16'h6000, 4'b1001);
    chk("R7 err clear", 32'(cfg_err), 0);
    wr(ra(3, RF_CODE_LO), 16'h0010);
    chk("R7 err set", 32'(cfg_err), 1);
    acc(16'h0200, 16'h6000, ACC_READ, 1, "R7 old bound kept");
    acc(16'h4000, 16'h6000, ACC_READ, 0, "R7 rule intact");

    // phase 2: fresh reset, table, lock
    do_reset();
    chk("R1 err after reset", 32'(cfg_err), 0);
    acc(16'h1000, 16'h2000, ACC_READ, 1, "R1 rules cleared");
    rule(0, 16'h1000, 16'h10FF, 16'h2000, 16'h20FF, 4'b1001);
    wr(ta(1, TF_CODE_LO), 16'h1000);
    wr(ta(1, TF_CODE_HI), 16'h10FF);
    wr(ta(1, TF_STACK),   16'h7FF0);
    rd("R9 code start", 1, 2'd0, 16'h1000);
    rd("R9 code end",   1, 2'd1, 16'h10FF);
    rd("R9 stack",      1, 2'd2, 16'h7FF0);
    rd("R9 field3",     1, 2'd3, 16'h0);
    wr(ta(1, TF_STACK), 16'hF000);
    rd("R7 table reject", 1, 2'd2, 16'h7FF0);
    chk("R7 table err", 32'(cfg_err), 1);

    do_reset();
    rule(0, 16'h1000, 16'h10FF, 16'h2000, 16'h20FF, 4'b1001);
    wr(ta(2, TF_STACK), 16'h7000);
    @(negedge clk); cfg_lock = 1'b1;
    @(negedge clk); cfg_lock = 1'b0;
    chk("R8 locked", 32'(locked), 1);
    chk("R8 err before write", 32'(cfg_err), 0);
    wr(ra(0, RF_PERM), 16'h000B);
    chk("R8 err on write", 32'(cfg_err), 1);
    acc(16'h1000, 16'h2000, ACC_WRITE, 1, "R8 rule frozen");
    acc(16'h1000, 16'h2000, ACC_READ,  0, "R8 rule still works");
    wr(ta(2, TF_STACK), 16'h7100);
    rd("R9 read after lock", 2, 2'd2, 16'h7000);
    repeat (3) @(negedge clk);
    chk("R8 lock persists", 32'(locked), 1);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule